// File: doc/BRIEF.md
# PTP Event Receive Classifier

This block decides, frame by frame, whether an arriving frame is a precision time protocol event that must have its receive time captured. An upstream parser presents the decoded header fields of one frame together with a single-cycle frame strobe. One clock later the block raises a one-cycle capture request for the timestamp unit whenever the frame matches the active configuration.

Two independent filters feed the decision. The layer-2 filter looks for the PTP Ethernet type. The layer-4 filter looks for an IPv4 UDP frame sent to the PTP event port, and can also require the source port to be the event port. A two-bit mode then chooses how the filter results and the PTP header fields are combined:

| Mode | Behaviour |
|------|-----------|
| `00` | off |
| `01` | version-1 over UDP, one selected message type |
| `10` | version-2 event messages over either layer |
| `11` | every frame |

The frame interface has no back-pressure. The block is always ready and takes one frame on every cycle in which the strobe is high, including back-to-back cycles.

Top module: `ptp_evt_classifier`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `cap_req` is 0.
- R2: `cap_req` rises only in the cycle after a cycle with `frm_valid` high, and stays high for that one cycle only. Back-to-back strobes give back-to-back requests.
- R3: With `mode` = 00 (off), no frame produces a request.
- R4: The layer-2 path matches only when both of the following hold:
  - `eth_type` is 0x88F7;
  - `l2_en` and `l2_ts_en` are both 1.
- R5: The layer-4 path matches only when all of the following hold:
  - `l4_en` is 1;
  - `is_ipv4` is 1;
  - `ip_proto` is 17 (UDP);
  - `udp_dst` is 319.

  All other header fields play no part.
- R6: When `src_chk` is 1, the layer-4 path also requires `udp_src` to be 319. When `src_chk` is 0, `udp_src` has no effect.
- R7: With `mode` = 01, a frame qualifies only when all of the following hold:
  - the layer-4 path matches;
  - `ptp_ver` is 1;
  - `v1_ctrl` equals the type chosen by `v1_sel`: 0 selects sync (control value 0) and 1 selects delay-request (control value 1).

  A layer-2-only match does not qualify.
- R8: With `mode` = 10, a frame qualifies only when all of the following hold:
  - `ptp_ver` is 2;
  - `msg_type` is below 4;
  - the layer-2 path or the layer-4 path matches.
- R9: With `mode` = 11, every strobed frame produces a request, whatever its fields.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Classification mode (00 off, 01 V1 UDP, 10 V2 event, 11 all) |
| v1_sel | input | 1 | V1 message choice: 0 sync, 1 delay-request |
| l2_en | input | 1 | Layer-2 filter enable |
| l2_ts_en | input | 1 | Layer-2 filter timestamp enable |
| l4_en | input | 1 | Layer-4 filter enable |
| src_chk | input | 1 | Require UDP source port equal to the event port |
| frm_valid | input | 1 | One-cycle strobe marking valid header fields |
| eth_type | input | 16 | Ethernet type field |
| is_ipv4 | input | 1 | Frame carries IPv4 |
| ip_proto | input | 8 | IP protocol number |
| udp_src | input | 16 | UDP source port |
| udp_dst | input | 16 | UDP destination port |
| ptp_ver | input | 4 | PTP version field |
| v1_ctrl | input | 8 | V1 control field |
| msg_type | input | 4 | V2 message type |
| cap_req | output | 1 | One-cycle timestamp capture request |

## Verification
The bench builds the block with its default parameters: Ethernet type 0x88F7, event port 319, a V2 event limit of 4, and the source-port comparator present. With these values the exact-match and one-off boundaries become reachable by direct stimulus: ports 319 and 320, message types 3 and 4, and the two V1 control codes. The frames are chosen so that each one misses a single condition at a time, which shows that every filter term is really applied. Mode changes, enable toggles and back-to-back strobes are covered as well.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;
  typedef enum logic [1:0] {
    PM_OFF    = 2'b00,
    PM_V1_UDP = 2'b01,
    PM_V2_EVT = 2'b10,
    PM_ALL    = 2'b11
  } ptp_mode_e;

  localparam logic [7:0] IPPROTO_UDP = 8'd17;
endpackage

// File: rtl/ptp_l2_filt.sv
module ptp_l2_filt #(
  parameter int          ETYPE_W = 16,
  parameter logic [15:0] ETH_PTP = 16'h88F7
) (
  input  logic               en,
  input  logic               ts_en,
  input  logic [ETYPE_W-1:0] eth_type,
  output logic               hit
);
  localparam logic [ETYPE_W-1:0] MATCH = ETYPE_W'(ETH_PTP);

  always_comb hit = en && ts_en && (eth_type == MATCH);
endmodule

// File: rtl/ptp_l4_filt.sv
module ptp_l4_filt #(
  parameter int PORT_W      = 16,
  parameter int EVT_PORT    = 319,
  parameter bit HAS_SRC_CHK = 1'b1
) (
  input  logic              en,
  input  logic              src_chk,
  input  logic              is_ipv4,
  input  logic [7:0]        ip_proto,
  input  logic [PORT_W-1:0] udp_src,
  input  logic [PORT_W-1:0] udp_dst,
  output logic              hit
);
  import ptp_cls_pkg::*;

  localparam logic [PORT_W-1:0] PORT = PORT_W'(EVT_PORT);

  logic src_ok;

  generate
    if (HAS_SRC_CHK) begin : g_src
      always_comb src_ok = !src_chk || (udp_src == PORT);
    end else begin : g_nosrc
      logic unused_src;
      always_comb unused_src = src_chk ^ (^udp_src);
      always_comb src_ok = 1'b1;
    end
  endgenerate

  always_comb
    hit = en && is_ipv4 && (ip_proto == IPPROTO_UDP) && (udp_dst == PORT) && src_ok;
endmodule

// File: rtl/ptp_mode_sel.sv
module ptp_mode_sel #(
  parameter int VER_W    = 4,
  parameter int MSG_W    = 4,
  parameter int EVT_LIM  = 4
) (
  input  ptp_cls_pkg::ptp_mode_e mode,
  input  logic                   v1_sel,
  input  logic                   l2_hit,
  input  logic                   l4_hit,
  input  logic [VER_W-1:0]       ptp_ver,
  input  logic [7:0]             v1_ctrl,
  input  logic [MSG_W-1:0]       msg_type,
  output logic                   qualify
);
  import ptp_cls_pkg::*;

  localparam logic [7:0]       CTRL_SYNC = 8'd0;
  localparam logic [7:0]       CTRL_DREQ = 8'd1;
  localparam logic [MSG_W-1:0] LIM       = MSG_W'(EVT_LIM);

  logic [7:0] want_ctrl;

  always_comb begin
    want_ctrl = v1_sel ? CTRL_DREQ : CTRL_SYNC;
    unique case (mode)
      PM_V1_UDP: qualify = l4_hit && (ptp_ver == VER_W'(1)) && (v1_ctrl == want_ctrl);
      PM_V2_EVT: qualify = (l2_hit || l4_hit) && (ptp_ver == VER_W'(2)) && (msg_type < LIM);
      PM_ALL:    qualify = 1'b1;
      default:   qualify = 1'b0;
    endcase
  end
endmodule

// File: rtl/ptp_evt_classifier.sv
module ptp_evt_classifier #(
  parameter int          ETYPE_W     = 16,
  parameter int          PORT_W      = 16,
  parameter int          VER_W       = 4,
  parameter int          MSG_W       = 4,
  parameter logic [15:0] ETH_PTP     = 16'h88F7,
  parameter int          EVT_PORT    = 319,
  parameter int          EVT_LIM     = 4,
  parameter bit          HAS_SRC_CHK = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode,
  input  logic               v1_sel,
  input  logic               l2_en,
  input  logic               l2_ts_en,
  input  logic               l4_en,
  input  logic               src_chk,
  input  logic               frm_valid,
  input  logic [ETYPE_W-1:0] eth_type,
  input  logic               is_ipv4,
  input  logic [7:0]         ip_proto,
  input  logic [PORT_W-1:0]  udp_src,
  input  logic [PORT_W-1:0]  udp_dst,
  input  logic [VER_W-1:0]   ptp_ver,
  input  logic [7:0]         v1_ctrl,
  input  logic [MSG_W-1:0]   msg_type,
  output logic               cap_req
);
  import ptp_cls_pkg::*;

  logic      l2_hit, l4_hit, qualify;
  ptp_mode_e mode_e;

  always_comb mode_e = ptp_mode_e'(mode);

  ptp_l2_filt #(.ETYPE_W(ETYPE_W), .ETH_PTP(ETH_PTP)) u_l2 (
    .en(l2_en), .ts_en(l2_ts_en), .eth_type(eth_type), .hit(l2_hit)
  );

  ptp_l4_filt #(.PORT_W(PORT_W), .EVT_PORT(EVT_PORT), .HAS_SRC_CHK(HAS_SRC_CHK)) u_l4 (
    .en(l4_en), .src_chk(src_chk), .is_ipv4(is_ipv4), .ip_proto(ip_proto),
    .udp_src(udp_src), .udp_dst(udp_dst), .hit(l4_hit)
  );

  ptp_mode_sel #(.VER_W(VER_W), .MSG_W(MSG_W), .EVT_LIM(EVT_LIM)) u_sel (
    .mode(mode_e), .v1_sel(v1_sel), .l2_hit(l2_hit), .l4_hit(l4_hit),
    .ptp_ver(ptp_ver), .v1_ctrl(v1_ctrl), .msg_type(msg_type), .qualify(qualify)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) cap_req <= 1'b0;
    else        cap_req <= frm_valid && qualify;
  end
endmodule

// File: rtl/ptp_evt_classifier_chk.sv
module ptp_evt_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       frm_valid,
  input logic       is_ipv4,
  input logic       cap_req
);
  // R2: no request without a strobe in the previous cycle
  a_r2_no_strobe_no_req: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_valid |=> !cap_req);

  // R3: off mode never requests
  a_r3_off_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && mode == 2'b00) |=> !cap_req);

  // R9: all mode always requests
  a_r9_all_frames: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && mode == 2'b11) |=> cap_req);

  // R7: V1 mode needs an IPv4 frame
  a_r7_v1_needs_ip: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && mode == 2'b01 && !is_ipv4) |=> !cap_req);

  // R1: output low while reset is held
  always @(posedge clk)
    if (!rst_n) a_r1_reset_low: assert (!cap_req || $past(rst_n));
endmodule

bind ptp_evt_classifier ptp_evt_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .frm_valid(frm_valid),
  .is_ipv4(is_ipv4), .cap_req(cap_req)
);

// File: tb/ptp_evt_classifier_tb.sv
module ptp_evt_classifier_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        v1_sel = 1'b0, l2_en = 1'b0, l2_ts_en = 1'b0, l4_en = 1'b0, src_chk = 1'b0;
  logic        frm_valid = 1'b0;
  logic [15:0] eth_type = '0;
  logic        is_ipv4 = 1'b0;
  logic [7:0]  ip_proto = '0;
  logic [15:0] udp_src = '0, udp_dst = '0;
  logic [3:0]  ptp_ver = '0;
  logic [7:0]  v1_ctrl = '0;
  logic [3:0]  msg_type = '0;
  logic        cap_req;

  int n_chk = 0, n_err = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ptp_evt_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .v1_sel(v1_sel), .l2_en(l2_en),
    .l2_ts_en(l2_ts_en), .l4_en(l4_en), .src_chk(src_chk), .frm_valid(frm_valid),
    .eth_type(eth_type), .is_ipv4(is_ipv4), .ip_proto(ip_proto), .udp_src(udp_src),
    .udp_dst(udp_dst), .ptp_ver(ptp_ver), .v1_ctrl(v1_ctrl), .msg_type(msg_type),
    .cap_req(cap_req)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: cap_req=%0b expected %0b", req, act, exp);
    end
  endtask

  // L2 PTP frame fields
  task automatic set_l2(input logic [3:0] ver, input logic [3:0] mt);
    eth_type = 16'h88F7; is_ipv4 = 1'b0; ip_proto = 8'd0;
    udp_src = 16'd0; udp_dst = 16'd0; ptp_ver = ver; msg_type = mt; v1_ctrl = 8'd0;
  endtask

  // L4 PTP frame fields
  task automatic set_l4(input logic [15:0] src, input logic [15:0] dst,
                        input logic [3:0] ver, input logic [7:0] ctrl, input logic [3:0] mt);
    eth_type = 16'h0800; is_ipv4 = 1'b1; ip_proto = 8'd17;
    udp_src = src; udp_dst = dst; ptp_ver = ver; v1_ctrl = ctrl; msg_type = mt;
  endtask

  // strobe one frame, check request in the next cycle and its fall after
  task automatic send(input string req, input logic exp);
    @(negedge clk) frm_valid = 1'b1;
    @(negedge clk) frm_valid = 1'b0;
    check(req, cap_req, exp);
    @(negedge clk);
    check("R2", cap_req, 1'b0);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk) check("R1", cap_req, 1'b0);
    @(negedge clk) frm_valid = 1'b1; mode = 2'b11;
    @(negedge clk) frm_valid = 1'b0; check("R1", cap_req, 1'b0);
    rst_n = 1'b1;
    @(negedge clk) check("R1", cap_req, 1'b0);
  endtask

  task automatic t_off;
    mode = 2'b00; l2_en = 1; l2_ts_en = 1; l4_en = 1;
    set_l2(4'd2, 4'd0); send("R3", 1'b0);
    set_l4(16'd319, 16'd319, 4'd1, 8'd0, 4'd0); send("R3", 1'b0);
  endtask

  task automatic t_all;
    mode = 2'b11; l2_en = 0; l4_en = 0;
    eth_type = 16'h1234; is_ipv4 = 0; ptp_ver = 4'd7;
    send("R9", 1'b1);
    @(negedge clk) check("R2", cap_req, 1'b0);
    // back-to-back strobes
    @(negedge clk) frm_valid = 1'b1;
    @(negedge clk) check("R2", cap_req, 1'b1);
    @(negedge clk) frm_valid = 1'b0; check("R2", cap_req, 1'b1);
    @(negedge clk) check("R2", cap_req, 1'b0);
  endtask

  task automatic t_l2;
    mode = 2'b10; l2_en = 1; l2_ts_en = 1; l4_en = 0;
    set_l2(4'd2, 4'd0); send("R4", 1'b1);
    l2_ts_en = 0; send("R4", 1'b0);
    l2_ts_en = 1; l2_en = 0; send("R4", 1'b0);
    l2_en = 1; eth_type = 16'h88F6; send("R4", 1'b0);
  endtask

  task automatic t_v2;
    mode = 2'b10; l2_en = 1; l2_ts_en = 1; l4_en = 1; src_chk = 0;
    set_l2(4'd2, 4'd3); send("R8", 1'b1);
    set_l2(4'd2, 4'd4); send("R8", 1'b0);
    set_l2(4'd1, 4'd0); send("R8", 1'b0);
    set_l4(16'd5000, 16'd319, 4'd2, 8'd0, 4'd1); send("R8", 1'b1);
    l4_en = 0; send("R8", 1'b0);
  endtask

  task automatic t_l4;
    mode = 2'b01; v1_sel = 0; l4_en = 1; l2_en = 1; l2_ts_en = 1; src_chk = 0;
    set_l4(16'd7, 16'd319, 4'd1, 8'd0, 4'd9); send("R5", 1'b1);
    ip_proto = 8'd6; send("R5", 1'b0);
    ip_proto = 8'd17; udp_dst = 16'd320; send("R5", 1'b0);
    udp_dst = 16'd319; is_ipv4 = 0; send("R5", 1'b0);
    is_ipv4 = 1; l4_en = 0; send("R5", 1'b0);
    l4_en = 1;
  endtask

  task automatic t_v1;
    mode = 2'b01; l4_en = 1; src_chk = 0;
    v1_sel = 0; set_l4(16'd1, 16'd319, 4'd1, 8'd1, 4'd0); send("R7", 1'b0);
    v1_sel = 1; send("R7", 1'b1);
    v1_ctrl = 8'd0; send("R7", 1'b0);
    v1_ctrl = 8'd1; ptp_ver = 4'd2; send("R7", 1'b0);
    l2_en = 1; l2_ts_en = 1; v1_sel = 0; set_l2(4'd1, 4'd0); send("R7", 1'b0);
  endtask

  task automatic t_src;
    mode = 2'b01; v1_sel = 0; l4_en = 1;
    src_chk = 1; set_l4(16'd1000, 16'd319, 4'd1, 8'd0, 4'd0); send("R6", 1'b0);
    udp_src = 16'd319; send("R6", 1'b1);
    src_chk = 0; udp_src = 16'd1000; send("R6", 1'b1);
  endtask

  initial begin
    t_reset;
    t_off;
    t_all;
    t_l2;
    t_v2;
    t_l4;
    t_v1;
    t_src;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: run did not finish, expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule